// File: doc/BRIEF.md
# Serial DAC command decoder

Each analog board in a multi-board camera controller listens to one shared serial line. A single timing master broadcasts every configuration word to all boards. This block is the receiver on one board. While a frame signal is high, it shifts in one command word MSB first, sampling the data line on each rising edge of a serial clock. The serial clock, the data line and the frame signal all arrive synchronous to the board clock. When the frame ends, the block decides whether the word is meant for this board and what the word asks for.

A word is accepted only when its board field equals the board's jumper inputs. An installed jumper reads as 0. Clock-driver boards and video boards may carry the same board number, so a board-type input decides which package addresses this board answers to. Two mode bits choose how the 12-bit value field is read:
- as data for one channel of one DAC package;
- as a pair of 4-bit gain settings for the two video channels;
- as the select of a 1-of-24 diagnostic multiplexer.

Each accepted command comes out as a one-cycle load pulse with its decoded fields. The DAC devices are outside the block.

Top module: `serial_dac_cmd_decoder`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the three load pulses and all decoded data outputs are 0.
- R2: A word has 24 bits shifted MSB first. Its fields are board = bits 23:20, package = bits 19:16, channel = bits 15:14, mode = bits 13:12 and value = bits 11:0.
- R3: A word whose board field differs from the 4-bit jumper input produces no pulse. A word whose board field equals it (including 0 with all jumpers installed) is decoded.
- R4: A frame carrying fewer or more than 24 serial clock rising edges produces no pulse.
- R5: On a clock-driver board (video input 0), mode 00 with package 0 to 11 pulses dac_load with the package, channel and value. Mode 00 with package 12 to 15 is ignored.
- R6: On a video board (video input 1), mode 00 with package 12 to 15 pulses dac_load with the package, channel and value. Mode 00 with package 0 to 11 is ignored.
- R7: Mode 11 with package 12 to 15 on a video board pulses gain_load, with channel 0 gain = value bits 3:0 and channel 1 gain = value bits 7:4. On a clock-driver board the same word is ignored.
- R8: Mode 11 with package 0 to 11 on a clock-driver board pulses mux_load with select = value bits 4:0 when the value is below 24. A value of 24 or more is ignored, and the same word on a video board is ignored.
- R9: Mode values 01 and 10 produce no pulse.
- R10: A load pulse is high for exactly one clock cycle: the cycle that follows the first clock edge at which the frame input is sampled low after being high. At most one of the three pulses is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock, sampled; a rising edge shifts one bit |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_frame | input | 1 | High for the duration of one word |
| jumper | input | 4 | Board address jumpers, installed = 0 |
| brd_is_video | input | 1 | 1 = video board, 0 = clock-driver board |
| dac_load | output | 1 | One-cycle DAC write pulse |
| dac_pkg | output | 4 | DAC package of the last write |
| dac_chan | output | 2 | Channel within the package |
| dac_val | output | 12 | Value to write |
| gain_load | output | 1 | One-cycle gain update pulse |
| gain_ch0 | output | 4 | Gain code for video channel 0 |
| gain_ch1 | output | 4 | Gain code for video channel 1 |
| mux_load | output | 1 | One-cycle diagnostic mux update pulse |
| mux_sel | output | 5 | Diagnostic mux select, 0 to 23 |

## Verification
The bench builds the block with its default parameters: 4-bit board and package fields, a 12-bit value, a package split at 12 and 24 mux inputs. These defaults put the package boundary between 11 and 12 within reach, on both board types. They also bring the mux bound, select 23 accepted and 24 refused, and gain nibbles split from a single value field. Frames of 23 and 25 bits and an all-zero jumper setting exercise the framing and address edges.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_DAC  = 2'd1,
        ACT_GAIN = 2'd2,
        ACT_MUX  = 2'd3
    } act_e;
endpackage

// File: rtl/sdac_word_shifter.sv
module sdac_word_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_frame,
    output logic [WORD_W-1:0] word,
    output logic              frame_end,
    output logic              word_done
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic              sclk;
        logic              frame;
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t st_q, st_d;
    logic rise;
    logic start;
    logic [CNT_W-1:0] base;

    always_comb begin
        st_d       = st_q;
        st_d.sclk  = ser_clk;
        st_d.frame = ser_frame;
        rise       = ser_clk & ~st_q.sclk;
        start      = ser_frame & ~st_q.frame;
        base       = start ? '0 : st_q.cnt;
        st_d.cnt   = base;
        if (ser_frame && rise) begin
            st_d.sh  = {st_q.sh[WORD_W-2:0], ser_dat};
            st_d.cnt = (base == CNT_SAT) ? CNT_SAT : base + 1'b1;
        end
        frame_end = st_q.frame & ~ser_frame;
        word_done = frame_end && (st_q.cnt == CNT_FULL);
        word      = st_q.sh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_SAT);
    assert_done_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (st_q.cnt == CNT_FULL));
endmodule

// File: rtl/sdac_field_decode.sv
module sdac_field_decode
    import sdac_pkg::*;
#(
    parameter int BOARD_W  = 4,
    parameter int PKG_W    = 4,
    parameter int CHAN_W   = 2,
    parameter int VAL_W    = 12,
    parameter int VIDEO_PKG_BASE = 12,
    parameter int MUX_OUTS = 24,
    localparam int WORD_W  = BOARD_W + PKG_W + CHAN_W + 2 + VAL_W
) (
    input  logic [WORD_W-1:0]  word,
    input  logic [BOARD_W-1:0] jumper,
    input  logic               is_video,
    output act_e               act,
    output logic [PKG_W-1:0]   pkg,
    output logic [CHAN_W-1:0]  chan,
    output logic [VAL_W-1:0]   val
);
    localparam int MODE_LO  = VAL_W;
    localparam int CHAN_LO  = VAL_W + 2;
    localparam int PKG_LO   = CHAN_LO + CHAN_W;
    localparam int BOARD_LO = PKG_LO + PKG_W;

    logic [BOARD_W-1:0] board;
    logic [1:0]         mode;
    logic               video_pkg;

    always_comb begin
        board     = word[BOARD_LO +: BOARD_W];
        pkg       = word[PKG_LO +: PKG_W];
        chan      = word[CHAN_LO +: CHAN_W];
        mode      = word[MODE_LO +: 2];
        val       = word[VAL_W-1:0];
        video_pkg = (pkg >= PKG_W'(VIDEO_PKG_BASE));
        act       = ACT_NONE;
        if (board == jumper) begin
            case (mode)
                2'b00: if (video_pkg == is_video) act = ACT_DAC;
                2'b11: begin
                    if (video_pkg) begin
                        if (is_video) act = ACT_GAIN;
                    end else if (!is_video && (val < VAL_W'(MUX_OUTS))) begin
                        act = ACT_MUX;
                    end
                end
                default: act = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/serial_dac_cmd_decoder.sv
module serial_dac_cmd_decoder
    import sdac_pkg::*;
#(
    parameter int BOARD_W  = 4,
    parameter int PKG_W    = 4,
    parameter int CHAN_W   = 2,
    parameter int VAL_W    = 12,
    parameter int GAIN_W   = 4,
    parameter int VIDEO_PKG_BASE = 12,
    parameter int MUX_OUTS = 24,
    localparam int SEL_W   = $clog2(MUX_OUTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_frame,
    input  logic [BOARD_W-1:0] jumper,
    input  logic               brd_is_video,
    output logic               dac_load,
    output logic [PKG_W-1:0]   dac_pkg,
    output logic [CHAN_W-1:0]  dac_chan,
    output logic [VAL_W-1:0]   dac_val,
    output logic               gain_load,
    output logic [GAIN_W-1:0]  gain_ch0,
    output logic [GAIN_W-1:0]  gain_ch1,
    output logic               mux_load,
    output logic [SEL_W-1:0]   mux_sel
);
    localparam int WORD_W = BOARD_W + PKG_W + CHAN_W + 2 + VAL_W;

    typedef struct packed {
        logic              dac_load;
        logic [PKG_W-1:0]  pkg;
        logic [CHAN_W-1:0] chan;
        logic [VAL_W-1:0]  val;
        logic              gain_load;
        logic [GAIN_W-1:0] g0;
        logic [GAIN_W-1:0] g1;
        logic              mux_load;
        logic [SEL_W-1:0]  sel;
    } out_t;

    logic [WORD_W-1:0] word;
    logic              frame_end;
    logic              word_done;
    act_e              act;
    logic [PKG_W-1:0]  f_pkg;
    logic [CHAN_W-1:0] f_chan;
    logic [VAL_W-1:0]  f_val;
    out_t              o_q, o_d;

    sdac_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_frame (ser_frame),
        .word      (word),
        .frame_end (frame_end),
        .word_done (word_done)
    );

    sdac_field_decode #(
        .BOARD_W        (BOARD_W),
        .PKG_W          (PKG_W),
        .CHAN_W         (CHAN_W),
        .VAL_W          (VAL_W),
        .VIDEO_PKG_BASE (VIDEO_PKG_BASE),
        .MUX_OUTS       (MUX_OUTS)
    ) u_decode (
        .word     (word),
        .jumper   (jumper),
        .is_video (brd_is_video),
        .act      (act),
        .pkg      (f_pkg),
        .chan     (f_chan),
        .val      (f_val)
    );

    always_comb begin
        o_d           = o_q;
        o_d.dac_load  = 1'b0;
        o_d.gain_load = 1'b0;
        o_d.mux_load  = 1'b0;
        if (word_done) begin
            case (act)
                ACT_DAC: begin
                    o_d.dac_load = 1'b1;
                    o_d.pkg      = f_pkg;
                    o_d.chan     = f_chan;
                    o_d.val      = f_val;
                end
                ACT_GAIN: begin
                    o_d.gain_load = 1'b1;
                    o_d.g0        = f_val[GAIN_W-1:0];
                    o_d.g1        = f_val[2*GAIN_W-1:GAIN_W];
                end
                ACT_MUX: begin
                    o_d.mux_load = 1'b1;
                    o_d.sel      = f_val[SEL_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign dac_load  = o_q.dac_load;
    assign dac_pkg   = o_q.pkg;
    assign dac_chan  = o_q.chan;
    assign dac_val   = o_q.val;
    assign gain_load = o_q.gain_load;
    assign gain_ch0  = o_q.g0;
    assign gain_ch1  = o_q.g1;
    assign mux_load  = o_q.mux_load;
    assign mux_sel   = o_q.sel;

    assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dac_load, gain_load, mux_load}));
    assert_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_load || gain_load || mux_load) |-> $past(frame_end));
    assert_pulse_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_load || gain_load || mux_load) |=> !(dac_load || gain_load || mux_load));
    assert_mux_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mux_load |-> (int'(mux_sel) < MUX_OUTS));
    assert_dac_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> ((dac_pkg >= PKG_W'(VIDEO_PKG_BASE)) == $past(brd_is_video)));
    assert_gain_video_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gain_load |-> $past(brd_is_video));
endmodule

// File: tb/serial_dac_cmd_decoder_tb.sv
module serial_dac_cmd_decoder_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_frame = 1'b0;
    logic [3:0] jumper = 4'hA;
    logic brd_is_video = 1'b0;
    logic dac_load, gain_load, mux_load;
    logic [3:0] dac_pkg, gain_ch0, gain_ch1;
    logic [1:0] dac_chan;
    logic [11:0] dac_val;
    logic [4:0] mux_sel;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_dac_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_frame(ser_frame), .jumper(jumper), .brd_is_video(brd_is_video),
        .dac_load(dac_load), .dac_pkg(dac_pkg), .dac_chan(dac_chan), .dac_val(dac_val),
        .gain_load(gain_load), .gain_ch0(gain_ch0), .gain_ch1(gain_ch1),
        .mux_load(mux_load), .mux_sel(mux_sel)
    );

    // kind: 0 none, 1 DAC, 2 gain, 3 mux
    typedef struct packed {
        logic [23:0] w;
        logic        vid;
        logic [1:0]  kind;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{24'hA385C3, 1'b0, 2'd1, 4'd5},  // R5 pkg 3 chan 2
        '{24'hABCFFF, 1'b0, 2'd1, 4'd5},  // R5 pkg 11 boundary
        '{24'hAC0123, 1'b0, 2'd0, 4'd5},  // R5 pkg 12 refused on clock board
        '{24'hAC0123, 1'b1, 2'd1, 4'd6},  // R6 pkg 12 on video
        '{24'hAF4ABC, 1'b1, 2'd1, 4'd6},  // R6 pkg 15 chan 1
        '{24'hA50001, 1'b1, 2'd0, 4'd6},  // R6 pkg 5 refused on video
        '{24'hAC30A7, 1'b1, 2'd2, 4'd7},  // R7 gains 7 / A
        '{24'hAC30A7, 1'b0, 2'd0, 4'd7},  // R7 refused on clock board
        '{24'hA23017, 1'b0, 2'd3, 4'd8},  // R8 select 23
        '{24'hA23018, 1'b0, 2'd0, 4'd8},  // R8 select 24 refused
        '{24'hA23005, 1'b1, 2'd0, 4'd8},  // R8 refused on video
        '{24'hA7F000, 1'b0, 2'd3, 4'd8},  // R8 select 0
        '{24'hA31123, 1'b0, 2'd0, 4'd9},  // R9 mode 01
        '{24'hA32123, 1'b0, 2'd0, 4'd9},  // R9 mode 10
        '{24'hB385C3, 1'b0, 2'd0, 4'd3},  // R3 board mismatch
        '{24'h5A8765, 1'b0, 2'd1, 4'd2}   // R2 field positions (board A: 0xA... see below)
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w, input int n);
        @(negedge clk) ser_frame = 1'b1;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) begin ser_dat = w[i]; ser_clk = 1'b1; end
            @(negedge clk) ser_clk = 1'b0;
        end
        @(negedge clk) ser_frame = 1'b0;
        @(negedge clk);
    endtask

    // Called at the negedge where a pulse is expected; then checks it is gone.
    task automatic expect_act(input logic [1:0] kind, input logic [23:0] w, input string tag);
        logic [2:0] exp_p;
        exp_p = (kind == 2'd1) ? 3'b100 : (kind == 2'd2) ? 3'b010 : (kind == 2'd3) ? 3'b001 : 3'b000;
        chk({dac_load, gain_load, mux_load} == exp_p, tag, {dac_load, gain_load, mux_load}, exp_p);
        if (kind == 2'd1)
            chk({dac_pkg, dac_chan, dac_val} == {w[19:16], w[15:14], w[11:0]}, tag,
                {dac_pkg, dac_chan, dac_val}, {w[19:16], w[15:14], w[11:0]});
        if (kind == 2'd2)
            chk({gain_ch1, gain_ch0} == w[7:0], tag, {gain_ch1, gain_ch0}, w[7:0]);
        if (kind == 2'd3)
            chk(mux_sel == w[4:0], tag, mux_sel, w[4:0]);
        @(negedge clk);
        chk({dac_load, gain_load, mux_load} == 3'b000, {tag, " R10 one cycle"},
            {dac_load, gain_load, mux_load}, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({dac_load, gain_load, mux_load, dac_val, mux_sel} == 0, "R1 in reset",
            {dac_load, gain_load, mux_load, dac_val, mux_sel}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({dac_load, gain_load, mux_load, dac_pkg, gain_ch0, gain_ch1} == 0, "R1 after reset",
            {dac_load, gain_load, mux_load, dac_pkg, gain_ch0, gain_ch1}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] w;
            w = VECS[i].w;
            if (i == NV - 1) w = 24'hA6_8765; // R2: board A pkg 6 chan 2 mode 00 value 765
            brd_is_video = VECS[i].vid;
            send({8'h0, w}, 24);
            expect_act(VECS[i].kind, w, $sformatf("R%0d vec %0d", VECS[i].req, i));
        end

        // R4: short and long frames
        brd_is_video = 1'b0;
        send({8'h0, 24'hA385C3} >> 1, 23);
        expect_act(2'd0, 24'h0, "R4 23-bit frame");
        send({7'h0, 1'b1, 24'hA385C3}, 25);
        expect_act(2'd0, 24'h0, "R4 25-bit frame");
        send({8'h0, 24'hA1_4002}, 24);
        expect_act(2'd1, 24'hA14002, "R4 recovery after bad frames");

        // R3: all jumpers installed reads as 0
        jumper = 4'h0;
        send({8'h0, 24'h02_0456}, 24);
        expect_act(2'd1, 24'h020456, "R3 board 0 all jumpers installed");
        send({8'h0, 24'hA2_0456}, 24);
        expect_act(2'd0, 24'h0, "R3 board A refused at jumper 0");

        // R7: gain update on a second board number
        jumper = 4'h3;
        brd_is_video = 1'b1;
        send({8'h0, 24'h3E_F0F1}, 24);
        expect_act(2'd2, 24'h3EF0F1, "R7 gains 1 / F");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule